// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This unit feeds an execution stage with whole instructions of one to six bytes. It reads one byte per memory transaction. The byte address is the code segment value shifted left by four bits plus the 16-bit instruction pointer. The first byte of each instruction is the opcode. The unit presents it on a lookup port and receives the instruction length back in the same cycle. It then reads the remaining bytes and packs them into a 48-bit instruction register in the order they were fetched, with no byte swapping. Once the instruction is complete, it holds the instruction valid until the execution side reports that it is done.

After reset the unit waits one idle cycle and then starts fetching from the current pointer. The execution side can load a new pointer at any time. A load abandons any fetch in progress and restarts at the new address. Opcode F4h is the halt instruction. It is delivered like any other one-byte instruction. Once it has been consumed, the unit stops fetching until the next reset.

Top module: `ifetch_unit`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `mem_req`, `instr_valid` and `halted` are 0 and `ip_out` is 0000h.
- R2: Every read address on `mem_addr` equals (cs_seg × 16 + ip_out) modulo 2^20.
- R3: Once `mem_req` is raised, it stays high with an unchanged `mem_addr` until a cycle in which `mem_ack` is high, unless a pointer load occurs. `mem_rdata` is sampled in the acknowledge cycle.
- R4: The length of an instruction is the lookup value returned on `len_value` for the opcode driven on `len_opcode`. The unit makes exactly that many reads and reports the length on `instr_len`.
- R5: Byte k of an instruction (k = 1 for the opcode) appears at `instr_reg[55-8k:48-8k]`. Bytes past the instruction length are zero.
- R6: `ip_out` increases by one for every acknowledged read and wraps from FFFFh to 0000h. When an instruction is delivered, it points at the byte after that instruction.
- R7: `instr_valid` and `instr_reg` hold steady until `exec_done` is high. In the following cycle the next opcode read begins.
- R8: A lookup value of 0 or above 6 makes the instruction one byte long, and `illegal_len` is 1 while that instruction is presented. `illegal_len` is 0 for legal lengths.
- R9: A pulse on `ip_load_en` outside the halted state sets `ip_out` to `ip_load_val` in the next cycle. The fetch in progress is dropped, and the next read uses the new address.
- R10: Opcode F4h always has length 1, whatever the lookup returns. After it has been delivered and `exec_done` is seen, `halted` becomes 1. From then on, `mem_req` stays 0 and pointer loads are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_seg | input | 16 | Code segment value |
| ip_load_en | input | 1 | Load a new instruction pointer and restart fetching |
| ip_load_val | input | 16 | Pointer value to load |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Byte read address |
| mem_ack | input | 1 | Read acknowledge, data valid this cycle |
| mem_rdata | input | 8 | Read data |
| len_opcode | output | 8 | Opcode presented to the length lookup |
| len_value | input | 4 | Length returned by the lookup |
| exec_done | input | 1 | Execution has consumed the presented instruction |
| instr_valid | output | 1 | A complete instruction is presented |
| instr_reg | output | 48 | Instruction bytes, opcode in the top byte |
| instr_len | output | 3 | Length of the presented instruction |
| ip_out | output | 16 | Current instruction pointer |
| illegal_len | output | 1 | Lookup gave an out-of-range length |
| halted | output | 1 | Halt instruction consumed, fetching stopped |

## Verification
The embedded properties watch several rules on every cycle. They check that a pending request keeps its address, that the pointer steps by one per acknowledged byte, and that a load lands in the pointer. They check that a presented instruction stays stable until it is consumed and that no read is made while one is presented. They also check that the halted state is silent and permanent. Other behaviour can only be shown by the bench, running against its own model with varied acknowledge latency: the packed byte order and zero fill, the lengths taken from the lookup, the handling of out-of-range lengths, the 16-bit pointer wrap, an abort in the middle of the operand bytes, and the forced one-byte length of the halt opcode.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_OPND,
    ST_READY,
    ST_HALT
  } fetch_state_t;

  localparam logic [7:0] HALT_OPCODE = 8'hF4;
endpackage

// File: rtl/ifetch_addr_gen.sv
module ifetch_addr_gen #(
  parameter int SEG_W     = 16,
  parameter int IP_W      = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [IP_W-1:0]   ptr,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    base = ADDR_W'(seg) << SEG_SHIFT;
    addr = base + ADDR_W'(ptr);
  end
endmodule

// File: rtl/ifetch_len_check.sv
module ifetch_len_check #(
  parameter int              BYTE_W  = 8,
  parameter int              LKP_W   = 4,
  parameter int              MAX_LEN = 6,
  parameter logic [BYTE_W-1:0] HALT_OP = 8'hF4,
  parameter int              LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic [BYTE_W-1:0] opcode,
  input  logic [LKP_W-1:0]  lkp,
  output logic [LEN_W-1:0]  len,
  output logic              illegal,
  output logic              is_halt
);
  always_comb begin
    is_halt = (opcode == HALT_OP);
    illegal = !is_halt && ((lkp == '0) || (lkp > LKP_W'(MAX_LEN)));
    if (is_halt || illegal) len = LEN_W'(1);
    else                    len = lkp[LEN_W-1:0];
  end
endmodule

// File: rtl/ifetch_ir_asm.sv
module ifetch_ir_asm #(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 6,
  parameter int IDX_W  = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    first_en,
  input  logic                    next_en,
  input  logic [IDX_W-1:0]        slot,
  input  logic [BYTE_W-1:0]       din,
  output logic [BYTE_W*SLOTS-1:0] ir
);
  localparam int IR_W = BYTE_W * SLOTS;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        ir[IR_W-1-g*BYTE_W -: BYTE_W] <= '0;
      end else if (first_en) begin
        if (g == 0) ir[IR_W-1-g*BYTE_W -: BYTE_W] <= din;
        else        ir[IR_W-1-g*BYTE_W -: BYTE_W] <= '0;
      end else if (next_en && slot == IDX_W'(g)) begin
        ir[IR_W-1-g*BYTE_W -: BYTE_W] <= din;
      end
    end
  end

  AST_FIRST_CLEARS_TAIL: assert property (@(posedge clk) disable iff (rst)
    first_en |=> ir[IR_W-BYTE_W-1:0] == '0) else $error("tail not cleared"); // R5
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifetch_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int IP_W      = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = 20,
  parameter int BYTE_W    = 8,
  parameter int MAX_LEN   = 6,
  parameter int LKP_W     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SEG_W-1:0]         cs_seg,
  input  logic                     ip_load_en,
  input  logic [IP_W-1:0]          ip_load_val,
  output logic                     mem_req,
  output logic [ADDR_W-1:0]        mem_addr,
  input  logic                     mem_ack,
  input  logic [BYTE_W-1:0]        mem_rdata,
  output logic [BYTE_W-1:0]        len_opcode,
  input  logic [LKP_W-1:0]         len_value,
  input  logic                     exec_done,
  output logic                     instr_valid,
  output logic [BYTE_W*MAX_LEN-1:0] instr_reg,
  output logic [$clog2(MAX_LEN+1)-1:0] instr_len,
  output logic [IP_W-1:0]          ip_out,
  output logic                     illegal_len,
  output logic                     halted
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int IDX_W = $clog2(MAX_LEN);

  fetch_state_t     state;
  logic [IP_W-1:0]  ip_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             ill_q;
  logic             halt_pend_q;

  logic [LEN_W-1:0] dec_len;
  logic             dec_ill;
  logic             dec_halt;
  logic             load_go;
  logic             take_opc;
  logic             take_opnd;

  assign load_go    = ip_load_en && (state != ST_HALT);
  assign take_opc   = (state == ST_OPC)  && mem_ack && !load_go;
  assign take_opnd  = (state == ST_OPND) && mem_ack && !load_go;
  assign mem_req    = (state == ST_OPC) || (state == ST_OPND);
  assign instr_valid = (state == ST_READY);
  assign halted     = (state == ST_HALT);
  assign len_opcode = mem_rdata;
  assign ip_out     = ip_q;
  assign instr_len  = len_q;
  assign illegal_len = ill_q;

  ifetch_addr_gen #(
    .SEG_W(SEG_W), .IP_W(IP_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
  ) u_addr (
    .seg(cs_seg), .ptr(ip_q), .addr(mem_addr)
  );

  ifetch_len_check #(
    .BYTE_W(BYTE_W), .LKP_W(LKP_W), .MAX_LEN(MAX_LEN),
    .HALT_OP(HALT_OPCODE), .LEN_W(LEN_W)
  ) u_len (
    .opcode(mem_rdata), .lkp(len_value),
    .len(dec_len), .illegal(dec_ill), .is_halt(dec_halt)
  );

  ifetch_ir_asm #(
    .BYTE_W(BYTE_W), .SLOTS(MAX_LEN), .IDX_W(IDX_W)
  ) u_ir (
    .clk(clk), .rst(rst),
    .first_en(take_opc), .next_en(take_opnd),
    .slot(cnt_q[IDX_W-1:0]), .din(mem_rdata),
    .ir(instr_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ip_q        <= '0;
      cnt_q       <= '0;
      len_q       <= '0;
      ill_q       <= 1'b0;
      halt_pend_q <= 1'b0;
    end else if (load_go) begin
      ip_q  <= ip_load_val;
      ill_q <= 1'b0;
      state <= ST_OPC;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_OPC;
        ST_OPC: if (mem_ack) begin
          ip_q        <= ip_q + IP_W'(1);
          len_q       <= dec_len;
          ill_q       <= dec_ill;
          halt_pend_q <= dec_halt;
          cnt_q       <= LEN_W'(1);
          state       <= (dec_len == LEN_W'(1)) ? ST_READY : ST_OPND;
        end
        ST_OPND: if (mem_ack) begin
          ip_q  <= ip_q + IP_W'(1);
          cnt_q <= cnt_q + LEN_W'(1);
          if (cnt_q + LEN_W'(1) == len_q) state <= ST_READY;
        end
        ST_READY: if (exec_done) state <= halt_pend_q ? ST_HALT : ST_OPC;
        ST_HALT: state <= ST_HALT;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !ip_load_en |=> mem_req && $stable(mem_addr)) else $error("request dropped"); // R3
  AST_IP_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && !ip_load_en |=> ip_out == IP_W'($past(ip_out) + IP_W'(1))) else $error("ip step"); // R6
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    instr_valid && !exec_done && !ip_load_en |=> instr_valid && $stable(instr_reg)) else $error("valid hold"); // R7
  AST_NO_REQ_WHILE_VALID: assert property (@(posedge clk) disable iff (rst)
    instr_valid |-> !mem_req) else $error("req while valid"); // R7
  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
    ip_load_en && !halted |=> ip_out == $past(ip_load_val) && mem_req) else $error("load"); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_req && !instr_valid) else $error("halt quiet"); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(ip_out)) else $error("halt sticky"); // R10
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    instr_valid |-> instr_len >= LEN_W'(1) && instr_len <= LEN_W'(MAX_LEN)) else $error("len range"); // R8
endmodule

// File: tb/ifetch_unit_tb_top.sv
`timescale 1ns/1ps
module ifetch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cs_seg = 16'h1000;
  logic        ip_load_en = 1'b0;
  logic [15:0] ip_load_val = '0;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  len_opcode;
  logic [3:0]  len_value;
  logic        exec_done = 1'b0;
  logic        instr_valid;
  logic [47:0] instr_reg;
  logic [2:0]  instr_len;
  logic [15:0] ip_out;
  logic        illegal_len;
  logic        halted;

  int checks = 0;
  int errors = 0;

  // length lookup table: low nibble of the opcode
  assign len_value = len_opcode[3:0];

  always #10 clk = ~clk;

  ifetch_unit dut_i (
    .clk(clk), .rst(rst), .cs_seg(cs_seg),
    .ip_load_en(ip_load_en), .ip_load_val(ip_load_val),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .len_opcode(len_opcode), .len_value(len_value), .exec_done(exec_done),
    .instr_valid(instr_valid), .instr_reg(instr_reg), .instr_len(instr_len),
    .ip_out(ip_out), .illegal_len(illegal_len), .halted(halted)
  );

  logic [7:0]  mem [int];
  int          m_ph;      // 0 idle, 1 opcode, 2 operands, 3 ready, 4 halted
  logic [15:0] m_ip;
  int          m_len;
  bit          m_ill;
  bit          m_hf;
  logic [7:0]  m_q [$];
  int          wc;
  int          lat;

  function automatic logic [7:0] rd(input logic [19:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h01;
  endfunction

  function automatic logic [47:0] packed_ir();
    logic [47:0] v = '0;
    for (int i = 0; i < m_q.size(); i++) v[47-8*i -: 8] = m_q[i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [19:0] ea;
    ea = 20'({cs_seg, 4'h0}) + 20'(m_ip);
    chk(mem_req == (m_ph == 1 || m_ph == 2), "R3 mem_req", 64'(mem_req), 64'(m_ph == 1 || m_ph == 2));
    if (mem_req) chk(mem_addr == ea, "R2 mem_addr", 64'(mem_addr), 64'(ea));
    chk(instr_valid == (m_ph == 3), "R7 instr_valid", 64'(instr_valid), 64'(m_ph == 3));
    chk(halted == (m_ph == 4), "R10 halted", 64'(halted), 64'(m_ph == 4));
    chk(ip_out == m_ip, "R6 ip_out", 64'(ip_out), 64'(m_ip));
    if (m_ph == 3) begin
      chk(instr_reg == packed_ir(), "R5 instr_reg", 64'(instr_reg), 64'(packed_ir()));
      chk(int'(instr_len) == m_len, "R4 instr_len", 64'(instr_len), 64'(m_len));
      chk(illegal_len == m_ill, "R8 illegal_len", 64'(illegal_len), 64'(m_ill));
    end
  endtask

  // one clock: drive inputs at a falling edge, predict, compare at the next falling edge
  task automatic cyc(input bit ld = 1'b0, input logic [15:0] lv = '0, input bit ed = 1'b0);
    bit   ack;
    int   lk;
    ack = 1'b0;
    if (mem_req && !ld) begin
      if (wc >= lat) begin ack = 1'b1; mem_rdata = rd(mem_addr); wc = 0; end
      else wc++;
    end else wc = 0;
    mem_ack = ack; ip_load_en = ld; ip_load_val = lv; exec_done = ed;
    if (ld && m_ph != 4) begin
      m_ip = lv; m_ph = 1; m_q.delete();
    end else begin
      case (m_ph)
        0: m_ph = 1;
        1: if (ack) begin
          lk = int'(mem_rdata[3:0]);
          m_hf = (mem_rdata == 8'hF4);
          m_ill = !m_hf && (lk < 1 || lk > 6);
          m_len = (m_hf || m_ill) ? 1 : lk;
          m_q.delete(); m_q.push_back(mem_rdata);
          m_ip = m_ip + 16'd1;
          m_ph = (m_len == 1) ? 3 : 2;
        end
        2: if (ack) begin
          m_q.push_back(mem_rdata);
          m_ip = m_ip + 16'd1;
          if (m_q.size() == m_len) m_ph = 3;
        end
        3: if (ed) m_ph = m_hf ? 4 : 1;
        default: ;
      endcase
    end
    @(negedge clk);
    compare();
  endtask

  task automatic run_ready();
    int n = 0;
    while (m_ph != 3 && n < 60) begin cyc(); n++; end
  endtask

  initial begin
    m_ph = 0; m_ip = '0; m_len = 0; m_ill = 0; m_hf = 0; wc = 0; lat = 0;
    mem[32'h13C08] = 8'h43; mem[32'h13C09] = 8'hA6; mem[32'h13C0A] = 8'h12;
    mem[32'h13C0B] = 8'h16; mem[32'h13C0C] = 8'h11; mem[32'h13C0D] = 8'h22;
    mem[32'h13C0E] = 8'h33; mem[32'h13C0F] = 8'h44; mem[32'h13C10] = 8'h55;
    mem[32'h13C11] = 8'h10; mem[32'h13C12] = 8'h2B;
    mem[32'h0FFFE] = 8'h02; mem[32'h0FFFF] = 8'h9C;
    mem[32'h00500] = 8'h16; mem[32'h00800] = 8'h43;
    mem[32'h00900] = 8'hF4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!mem_req && !instr_valid && !halted && ip_out == 16'h0, "R1 reset state",
        {mem_req, instr_valid, halted, ip_out}, 64'h0);
    compare();
    // first instruction at 1000:0000, default byte 01 -> length 1
    run_ready();
    chk(instr_reg == 48'h010000000000, "R4 one-byte instr", 64'(instr_reg), 64'h010000000000);
    // load 3C08 while presenting: three-byte instruction
    cyc(1'b1, 16'h3C08);
    run_ready();
    chk(instr_reg == 48'h43A612000000, "R5 fetch order", 64'(instr_reg), 64'h43A612000000);
    chk(ip_out == 16'h3C0B, "R6 pointer past instr", 64'(ip_out), 64'h3C0B);
    chk(instr_len == 3'd3, "R4 length 3", 64'(instr_len), 64'd3);
    repeat (3) cyc();
    chk(instr_valid == 1'b1, "R7 held without exec_done", 64'(instr_valid), 64'd1);
    // six-byte instruction with slow memory
    lat = 2;
    cyc(1'b0, 16'h0, 1'b1);
    chk(mem_req == 1'b1, "R7 fetch after exec_done", 64'(mem_req), 64'd1);
    run_ready();
    chk(instr_reg == 48'h161122334455, "R5 six bytes", 64'(instr_reg), 64'h161122334455);
    chk(ip_out == 16'h3C11, "R6 pointer after six", 64'(ip_out), 64'h3C11);
    // out-of-range lengths: 0 and 11
    lat = 0;
    cyc(1'b0, 16'h0, 1'b1);
    run_ready();
    chk(illegal_len && instr_len == 3'd1, "R8 length 0", {illegal_len, 1'b0, instr_len}, 64'h11);
    cyc(1'b0, 16'h0, 1'b1);
    run_ready();
    chk(illegal_len && instr_len == 3'd1 && ip_out == 16'h3C13, "R8 length 11",
        {illegal_len, instr_len, ip_out}, {1'b1, 3'd1, 16'h3C13});
    // pointer wrap at 16 bits
    cs_seg = 16'h0000;
    cyc(1'b1, 16'hFFFE);
    run_ready();
    chk(ip_out == 16'h0000, "R6 pointer wrap", 64'(ip_out), 64'h0);
    chk(instr_reg == 48'h029C00000000, "R5 wrap bytes", 64'(instr_reg), 64'h029C00000000);
    cyc(1'b0, 16'h0, 1'b1);
    chk(mem_req && mem_addr == 20'h00000, "R2 address after wrap", 64'(mem_addr), 64'h0);
    run_ready();
    // abort in the middle of operand bytes
    lat = 1;
    cyc(1'b1, 16'h0500);
    for (int n = 0; n < 40 && !(m_ph == 2 && m_q.size() == 2); n++) cyc();
    cyc(1'b1, 16'h0800);
    chk(mem_req && mem_addr == 20'h00800, "R9 restart address", 64'(mem_addr), 64'h00800);
    run_ready();
    chk(instr_reg == 48'h430101000000 && ip_out == 16'h0803, "R9 refetched instr",
        64'(instr_reg), 64'h430101000000);
    // halt opcode: lookup says 4, length forced to 1
    cyc(1'b1, 16'h0900);
    run_ready();
    chk(instr_len == 3'd1 && !illegal_len, "R10 halt length", 64'(instr_len), 64'd1);
    chk(!halted, "R10 not halted before exec_done", 64'(halted), 64'd0);
    cyc(1'b0, 16'h0, 1'b1);
    chk(halted && !mem_req, "R10 halted", {halted, mem_req}, 64'h2);
    cyc(1'b1, 16'h0100);
    repeat (10) cyc();
    chk(halted && !mem_req && ip_out == 16'h0901, "R10 load ignored when halted",
        64'(ip_out), 64'h0901);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule